// File: doc/BRIEF.md
# Guarded Configuration Register Bank

This block is an 8-bit register bank that sits behind a serial host link. The link is decoded elsewhere into a single-cycle write strobe and a read strobe, each with an address. The bank holds several kinds of register: a status word, a general control word, and settings for output data format, averaging, timing, channel scanning, pin and GPIO control, an unlock key and a diagnostics group. Reads return the addressed byte one cycle after the read strobe.

Writes are gated in two independent ways. When an input-integrity error pulse arrives, a sticky flag locks the bank, and only addresses 0x00 and 0x01 stay writable until software clears the flag. The three diagnostics registers at 0xC0 to 0xC2 accept writes only while the key register at 0xBF holds the unlock code (default 0x96). The status word mixes write-1-to-clear flags with fixed and live bits. The general word carries two command bits that clear themselves: a software reset and a calibration request.

A small control state machine sequences the command bits. It has three states:
- CTL_RUN is idle.
- CTL_CAL means a calibration request is outstanding.
- CTL_SWRST lasts one cycle and applies the software reset.

The transitions are:
- CTL_RUN moves to CTL_SWRST on an accepted write of 1 to the reset bit.
- Otherwise, CTL_RUN moves to CTL_CAL on an accepted write of 1 to the calibrate bit.
- CTL_CAL moves to CTL_SWRST on a reset write.
- Otherwise, CTL_CAL moves to CTL_RUN when the calibration-done input is high.
- CTL_SWRST always returns to CTL_RUN.

Top module: `cfg_regbank`

## Requirements
- R1: Reading address 0x00 returns bit 7 = 1, bit 6 = the level of `seq_busy_i`, and bits 5:2 = 0. Writing 1 to bits 7:2 of address 0x00 has no effect.
- R2: The brown-out flag (address 0x00 bit 0) is 1 after hardware reset. A write of 1 to that bit clears it and a write of 0 leaves it unchanged. Only a software reset sets it again.
- R3: The integrity-error flag (address 0x00 bit 1) is set by a one-cycle pulse on `crc_err_i` and cleared by writing 1 to it. If a pulse and a clear arrive in the same cycle, the flag ends up set.
- R4: While the integrity-error flag is set, every write to an address other than 0x00 or 0x01 is discarded.
- R5: An accepted write with bit 0 = 1 to address 0x01 raises `soft_rst_o` for exactly one cycle. On the following edge every register returns to its reset value, the brown-out flag becomes 1 and the integrity-error flag becomes 0. Bit 0 of address 0x01 always reads 0.
- R6: Writing 1 to bit 1 of address 0x01 sets the calibration request. The request reads back as bit 1 = 1 and drives `cal_req_o` high. It stays set, even through later writes of 0, until `cal_done_i` is high at a clock edge, after which it reads 0.
- R7: Addresses 0xC0, 0xC1 and 0xC2 change only on writes made while the key register at 0xBF holds 0x96. Any other key value blocks those writes.
- R8: After reset, address 0x04 reads 0x04, address 0x00 reads 0x81 (with `seq_busy_i` low), and every other listed read/write register reads 0x00.
- R9: Only implemented bits store data and all other bits read 0. The implemented bits per address are: 0x01 -> 0xCC plus the calibrate bit; 0x02 -> 0xB3; 0x03 -> 0x07; 0x04 -> 0x1F; 0x05 to 0x08 -> 0xFF; 0x0A -> 0x13; 0x0B -> 0x0F; 0x0C -> 0xFF; 0xBF -> 0xFF; 0xC0 -> 0x11; 0xC1 and 0xC2 -> 0xFF.
- R10: Address 0x09 is read-only and returns `gpio_in_i`. Any address not listed in R9 reads 0x00, and writes to such addresses change nothing.
- R11: `rd_data` shows the addressed value one clock after `rd_en` and holds when `rd_en` is low. A read and a write to the same address in the same cycle return the old value.
- R12: `pin_gpio_o`, `gpo_dir_o` and `gpo_val_o` always equal the contents of addresses 0x05, 0x06 and 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| crc_err_i | input | 1 | Integrity-error pulse from the link decoder |
| cal_done_i | input | 1 | Calibration finished |
| seq_busy_i | input | 1 | Channel sequencer running |
| gpio_in_i | input | 8 | Sampled GPIO pin levels |
| cal_req_o | output | 1 | Calibration request outstanding |
| soft_rst_o | output | 1 | One-cycle software reset indication |
| pin_gpio_o | output | 8 | Per-channel GPIO selection |
| gpo_dir_o | output | 8 | GPIO direction, 1 = output |
| gpo_val_o | output | 8 | GPIO output levels |

## Verification
The assertions check the following on every cycle:
- Status bit 7 is present on every status read.
- An error pulse always sets the flag.
- Writes are discarded under lockout and under a wrong key.
- The reset pulse lasts one cycle and is followed by the full default image and a set brown-out flag.
- The calibration request drops after the done input.
- The brown-out flag never sets on its own.

The following can only be shown by the bench's scenarios, which sweep all 256 addresses after reset, after all-ones writes and after a patterned write:
- The per-address masks.
- The values read from unlisted addresses.
- The read latency and its hold behaviour.
- The priority when a clear and a pulse land in the same cycle.

// File: rtl/cfg_regbank_pkg.sv
`timescale 1ns/1ps
package cfg_regbank_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NSLOT = 14;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        CTL_RUN   = 2'd0,
        CTL_CAL   = 2'd1,
        CTL_SWRST = 2'd2
    } ctl_state_e;

    localparam addr_t ADR_STAT    = 8'h00;
    localparam addr_t ADR_GEN     = 8'h01;
    localparam addr_t ADR_GIN     = 8'h09;
    localparam addr_t ADR_DIAG_LO = 8'hC0;
    localparam addr_t ADR_DIAG_HI = 8'hC2;

    localparam byte_t GEN_STORE_MASK = 8'hCC;
    localparam byte_t STAT_FIXED     = 8'h80;

    localparam int GEN_RST_BIT = 0;
    localparam int GEN_CAL_BIT = 1;
    localparam int ST_BOR_BIT  = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_SEQ_BIT  = 6;

    localparam int SL_PINM = 3;
    localparam int SL_GDIR = 4;
    localparam int SL_GOUT = 6;
    localparam int SL_KEY  = 10;

    function automatic addr_t slot_addr(input int s);
        case (s)
            0:       return 8'h02;
            1:       return 8'h03;
            2:       return 8'h04;
            3:       return 8'h05;
            4:       return 8'h06;
            5:       return 8'h07;
            6:       return 8'h08;
            7:       return 8'h0A;
            8:       return 8'h0B;
            9:       return 8'h0C;
            10:      return 8'hBF;
            11:      return 8'hC0;
            12:      return 8'hC1;
            13:      return 8'hC2;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic byte_t slot_mask(input int s);
        case (s)
            0:       return 8'hB3;
            1:       return 8'h07;
            2:       return 8'h1F;
            7:       return 8'h13;
            8:       return 8'h0F;
            11:      return 8'h11;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic byte_t slot_rst(input int s);
        if (s == 2) return 8'h04;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfg_wr_gate.sv
`timescale 1ns/1ps
module cfg_wr_gate
    import cfg_regbank_pkg::*;
#(
    parameter byte_t UNLOCK_CODE = 8'h96,
    parameter addr_t OPEN_TOP    = 8'h01
) (
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  logic  locked,
    input  byte_t key_q,
    output logic  wr_ok
);

    logic exempt;
    logic is_diag;
    logic key_open;

    always_comb begin
        exempt   = (wr_addr <= OPEN_TOP);
        is_diag  = (wr_addr >= ADR_DIAG_LO) && (wr_addr <= ADR_DIAG_HI);
        key_open = (key_q == UNLOCK_CODE);
        wr_ok    = wr_en && (!locked || exempt) && (!is_diag || key_open);
    end

endmodule

// File: rtl/cfg_ctl_fsm.sv
`timescale 1ns/1ps
module cfg_ctl_fsm
    import cfg_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gen_wr,
    input  logic rst_bit,
    input  logic cal_bit,
    input  logic cal_done,
    output logic cal_busy,
    output logic soft_clr
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_RUN: begin
                if (gen_wr && rst_bit)      state_d = CTL_SWRST;
                else if (gen_wr && cal_bit) state_d = CTL_CAL;
            end
            CTL_CAL: begin
                if (gen_wr && rst_bit)      state_d = CTL_SWRST;
                else if (cal_done)          state_d = CTL_RUN;
            end
            CTL_SWRST: state_d = CTL_RUN;
            default:   state_d = CTL_RUN;
        endcase
    end

    always_comb begin
        cal_busy = 1'b0;
        soft_clr = 1'b0;
        unique case (state_q)
            CTL_RUN:   ;
            CTL_CAL:   cal_busy = 1'b1;
            CTL_SWRST: soft_clr = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/cfg_slot_store.sv
`timescale 1ns/1ps
module cfg_slot_store
    import cfg_regbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  soft_clr,
    input  logic  wr_ok,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    output byte_t slots_q [NSLOT]
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam addr_t SA = slot_addr(s);
        localparam byte_t SM = slot_mask(s);
        localparam byte_t SR = slot_rst(s);
        byte_t r_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       r_q <= SR;
            else if (soft_clr)                r_q <= SR;
            else if (wr_ok && wr_addr == SA)  r_q <= wr_data & SM;
        end

        assign slots_q[s] = r_q;
    end

endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/1ps
module cfg_regbank
    import cfg_regbank_pkg::*;
#(
    parameter logic [7:0] UNLOCK_CODE = 8'h96,
    parameter logic [7:0] OPEN_TOP    = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       crc_err_i,
    input  logic       cal_done_i,
    input  logic       seq_busy_i,
    input  logic [7:0] gpio_in_i,
    output logic       cal_req_o,
    output logic       soft_rst_o,
    output logic [7:0] pin_gpio_o,
    output logic [7:0] gpo_dir_o,
    output logic [7:0] gpo_val_o
);

    byte_t slots_q [NSLOT];
    logic [NSLOT*DW-1:0] slots_flat;
    logic  wr_ok;
    logic  stat_wr;
    logic  gen_wr;
    logic  crc_q;
    logic  brown_q;
    byte_t gen_q;
    logic  cal_busy;
    logic  soft_clr;
    byte_t rd_val;

    for (genvar s = 0; s < NSLOT; s++) begin : g_flat
        assign slots_flat[s*DW +: DW] = slots_q[s];
    end

    cfg_wr_gate #(
        .UNLOCK_CODE (UNLOCK_CODE),
        .OPEN_TOP    (OPEN_TOP)
    ) u_gate (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .locked  (crc_q),
        .key_q   (slots_q[SL_KEY]),
        .wr_ok   (wr_ok)
    );

    assign stat_wr = wr_ok && (wr_addr == ADR_STAT);
    assign gen_wr  = wr_ok && (wr_addr == ADR_GEN);

    cfg_ctl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_wr   (gen_wr),
        .rst_bit  (wr_data[GEN_RST_BIT]),
        .cal_bit  (wr_data[GEN_CAL_BIT]),
        .cal_done (cal_done_i),
        .cal_busy (cal_busy),
        .soft_clr (soft_clr)
    );

    cfg_slot_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .wr_ok    (wr_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .slots_q  (slots_q)
    );

    // Integrity-error flag: a pulse outranks both the soft reset and a clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                crc_q <= 1'b0;
        else if (crc_err_i)                        crc_q <= 1'b1;
        else if (soft_clr)                         crc_q <= 1'b0;
        else if (stat_wr && wr_data[ST_ERR_BIT])   crc_q <= 1'b0;
    end

    // Brown-out flag: set by any reset, cleared only by writing 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                brown_q <= 1'b1;
        else if (soft_clr)                         brown_q <= 1'b1;
        else if (stat_wr && wr_data[ST_BOR_BIT])   brown_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        gen_q <= '0;
        else if (soft_clr) gen_q <= '0;
        else if (gen_wr)   gen_q <= wr_data & GEN_STORE_MASK;
    end

    always_comb begin
        rd_val = '0;
        if (rd_addr == ADR_STAT) begin
            rd_val              = STAT_FIXED;
            rd_val[ST_SEQ_BIT]  = seq_busy_i;
            rd_val[ST_ERR_BIT]  = crc_q;
            rd_val[ST_BOR_BIT]  = brown_q;
        end else if (rd_addr == ADR_GEN) begin
            rd_val              = gen_q;
            rd_val[GEN_CAL_BIT] = cal_busy;
        end else if (rd_addr == ADR_GIN) begin
            rd_val = gpio_in_i;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                if (rd_addr == slot_addr(s)) rd_val = slots_q[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_val;
    end

    assign cal_req_o  = cal_busy;
    assign soft_rst_o = soft_clr;
    assign pin_gpio_o = slots_q[SL_PINM];
    assign gpo_dir_o  = slots_q[SL_GDIR];
    assign gpo_val_o  = slots_q[SL_GOUT];

endmodule

// File: rtl/cfg_regbank_chk.sv
`timescale 1ns/1ps
module cfg_regbank_chk
    import cfg_regbank_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [7:0]          wr_addr,
    input logic                rd_en,
    input logic [7:0]          rd_addr,
    input logic [7:0]          rd_data,
    input logic                crc_err_i,
    input logic                cal_done_i,
    input logic                cal_req_o,
    input logic                soft_rst_o,
    input logic                crc_q,
    input logic                brown_q,
    input logic [7:0]          unlock_code,
    input logic [NSLOT*DW-1:0] slots_flat
);

    function automatic logic [NSLOT*DW-1:0] rst_image();
        logic [NSLOT*DW-1:0] v;
        v = '0;
        for (int s = 0; s < NSLOT; s++) v[s*DW +: DW] = slot_rst(s);
        return v;
    endfunction

    logic [7:0] key_now;
    logic       diag_hit;
    assign key_now  = slots_flat[SL_KEY*DW +: DW];
    assign diag_hit = (wr_addr >= ADR_DIAG_LO) && (wr_addr <= ADR_DIAG_HI);

    AST_STAT_TOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADR_STAT) |=> rd_data[7]); // R1

    AST_BROWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!brown_q && !soft_rst_o) |=> !brown_q); // R2

    AST_ERR_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_i |=> crc_q); // R3

    AST_LOCK_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_q && wr_en && wr_addr > 8'h01 && !soft_rst_o) |=> $stable(slots_flat)); // R4

    AST_SWRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (!soft_rst_o && brown_q && !crc_q)); // R5

    AST_CAL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req_o && cal_done_i) |=> !cal_req_o); // R6

    AST_DIAG_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && diag_hit && key_now != unlock_code && !soft_rst_o) |=> $stable(slots_flat)); // R7

    AST_SWRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (slots_flat == rst_image())); // R8

endmodule

bind cfg_regbank cfg_regbank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .crc_err_i   (crc_err_i),
    .cal_done_i  (cal_done_i),
    .cal_req_o   (cal_req_o),
    .soft_rst_o  (soft_rst_o),
    .crc_q       (crc_q),
    .brown_q     (brown_q),
    .unlock_code (UNLOCK_CODE),
    .slots_flat  (slots_flat)
);

// File: tb/tb_cfg_regbank.sv
`timescale 1ns/1ps
module tb_cfg_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       crc_err_i = 1'b0;
    logic       cal_done_i = 1'b0;
    logic       seq_busy_i = 1'b0;
    logic [7:0] gpio_in_i = 8'h3C;
    logic       cal_req_o;
    logic       soft_rst_o;
    logic [7:0] pin_gpio_o;
    logic [7:0] gpo_dir_o;
    logic [7:0] gpo_val_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cfg_regbank dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .crc_err_i(crc_err_i), .cal_done_i(cal_done_i), .seq_busy_i(seq_busy_i),
        .gpio_in_i(gpio_in_i), .cal_req_o(cal_req_o), .soft_rst_o(soft_rst_o),
        .pin_gpio_o(pin_gpio_o), .gpo_dir_o(gpo_dir_o), .gpo_val_o(gpo_val_o)
    );

    // Implemented-bit masks per address, taken from R9 (R10 for unlisted: 0).
    function automatic logic [7:0] exp_mask(input logic [7:0] a);
        case (a)
            8'h02: return 8'hB3;
            8'h03: return 8'h07;
            8'h04: return 8'h1F;
            8'h05, 8'h06, 8'h07, 8'h08: return 8'hFF;
            8'h0A: return 8'h13;
            8'h0B: return 8'h0F;
            8'h0C, 8'hBF, 8'hC1, 8'hC2: return 8'hFF;
            8'hC0: return 8'h11;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rst(input logic [7:0] a);
        return (a == 8'h04) ? 8'h04 : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic err_pulse();
        @(negedge clk); crc_err_i = 1'b1;
        @(negedge clk); crc_err_i = 1'b0;
    endtask

    task automatic sweep_reset_image(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), v);
            if (a == 0)      chk({tag, " R1 status"}, v, 8'h81);
            else if (a == 9) chk({tag, " R10 gpio in"}, v, gpio_in_i);
            else             chk({tag, " R8 default"}, v, exp_rst(8'(a)));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R10: full sweep of reset contents
        sweep_reset_image("hw reset");
        chk("R12 outputs after reset", gpo_dir_o | gpo_val_o | pin_gpio_o, 8'h00);

        // R9 / R10 / R7: all-ones write sweep, diagnostics still keyed off
        for (int a = 2; a < 256; a++) wr(8'(a), 8'hFF);
        for (int a = 2; a < 256; a++) begin
            rd(8'(a), v);
            if (a == 9)                     chk("R10 gpio in read-only", v, gpio_in_i);
            else if (a >= 8'hC0 && a <= 8'hC2) chk("R7 diag blocked", v, 8'h00);
            else                            chk("R9 ones mask", v, exp_mask(8'(a)));
        end
        chk("R12 pin_gpio_o", pin_gpio_o, 8'hFF);
        chk("R12 gpo_dir_o", gpo_dir_o, 8'hFF);
        chk("R12 gpo_val_o", gpo_val_o, 8'hFF);

        // R7: unlock, write diagnostics, lock again
        wr(8'hBF, 8'h96);
        for (int a = 8'hC0; a <= 8'hC2; a++) wr(8'(a), 8'hFF);
        for (int a = 8'hC0; a <= 8'hC2; a++) begin
            rd(8'(a), v);
            chk("R7 diag unlocked write", v, exp_mask(8'(a)));
        end
        wr(8'hBF, 8'h00);
        wr(8'hC1, 8'h00);
        rd(8'hC1, v); chk("R7 diag relocked", v, 8'hFF);

        // R9: patterned sweep; key becomes 0x5A so diagnostics keep their values
        for (int a = 2; a < 256; a++) wr(8'(a), 8'h5A);
        for (int a = 2; a < 256; a++) begin
            rd(8'(a), v);
            if (a == 9)                     chk("R10 gpio in", v, gpio_in_i);
            else if (a >= 8'hC0 && a <= 8'hC2) chk("R7 diag kept", v, exp_mask(8'(a)));
            else                            chk("R9 pattern mask", v, 8'h5A & exp_mask(8'(a)));
        end
        chk("R12 gpo_val_o pattern", gpo_val_o, 8'h5A);
        gpio_in_i = 8'hC3;
        rd(8'h09, v); chk("R10 gpio in follows pins", v, 8'hC3);

        // R11: latency, hold, read-during-write
        @(negedge clk); rd_en = 1'b1; rd_addr = 8'h03;
        @(negedge clk); rd_en = 1'b0; rd_addr = 8'h0C;
        chk("R11 one-cycle latency", rd_data, 8'h02);
        @(negedge clk);
        chk("R11 hold without strobe", rd_data, 8'h02);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h0C; wr_en = 1'b1; wr_addr = 8'h0C; wr_data = 8'h33;
        @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
        chk("R11 read returns old value", rd_data, 8'h5A);
        rd(8'h0C, v); chk("R11 new value after write", v, 8'h33);

        // R1: status layout with sequencer busy
        seq_busy_i = 1'b1;
        wr(8'h00, 8'hFC);
        rd(8'h00, v); chk("R1 status busy, bits 5:2 zero", v, 8'hC1);
        seq_busy_i = 1'b0;

        // R2: brown-out flag
        wr(8'h00, 8'h00);
        rd(8'h00, v); chk("R2 write 0 keeps flag", v, 8'h81);
        wr(8'h00, 8'h01);
        rd(8'h00, v); chk("R2 write 1 clears flag", v, 8'h80);

        // R3 / R4: error flag and lockout
        err_pulse();
        rd(8'h00, v); chk("R3 pulse sets flag", v, 8'h82);
        wr(8'h02, 8'h00);
        rd(8'h02, v); chk("R4 locked write discarded", v, 8'h12);
        wr(8'h08, 8'h00);
        chk("R4 locked gpo value kept", gpo_val_o, 8'h5A);
        wr(8'h01, 8'h80);
        rd(8'h01, v); chk("R4 address 0x01 still writable", v, 8'h80);
        wr(8'h00, 8'h02);
        rd(8'h00, v); chk("R3 write 1 clears flag", v, 8'h80);
        wr(8'h02, 8'h00);
        rd(8'h02, v); chk("R4 unlocked write lands", v, 8'h00);
        @(negedge clk);
        crc_err_i = 1'b1; wr_en = 1'b1; wr_addr = 8'h00; wr_data = 8'h02;
        @(negedge clk);
        crc_err_i = 1'b0; wr_en = 1'b0;
        rd(8'h00, v); chk("R3 pulse beats clear", v, 8'h82);
        wr(8'h00, 8'h02);

        // R6: calibration request
        wr(8'h01, 8'h02);
        chk("R6 cal_req_o raised", {7'd0, cal_req_o}, 8'h01);
        rd(8'h01, v); chk("R6 cal bit reads 1", v, 8'h02);
        wr(8'h01, 8'h00);
        rd(8'h01, v); chk("R6 write 0 does not abort", v, 8'h02);
        @(negedge clk); cal_done_i = 1'b1;
        @(negedge clk); cal_done_i = 1'b0;
        chk("R6 cal_req_o released", {7'd0, cal_req_o}, 8'h00);
        rd(8'h01, v); chk("R6 cal bit reads 0", v, 8'h00);

        // R5: software reset while locked out
        err_pulse();
        wr(8'h01, 8'hC1);
        chk("R5 soft_rst_o pulse", {7'd0, soft_rst_o}, 8'h01);
        @(negedge clk);
        chk("R5 soft_rst_o single cycle", {7'd0, soft_rst_o}, 8'h00);
        rd(8'h01, v); chk("R5 reset bit reads 0", v, 8'h00);
        sweep_reset_image("R5 soft reset");

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule